// File: doc/BRIEF.md
# Split-Transaction Outstanding Request Table

This block is the per-client bookkeeping table for a bus whose transactions are split into a request phase and a later response phase. It watches grants on the request bus. Each granted read or read-for-ownership takes a free entry, and the index of that entry is the transaction tag. The tag is presented to the arbiter on `gnt_tag` for the grant in that cycle. The entry records the source client, the cache-line address and the operation. It is released when a response with that tag appears. Responses may return in any order. Upgrades and write-backs have no response phase, so they never take an entry.

The local cache controller asks the table about the request it wants to send next. The table answers in the same cycle. The request must be held while a conflicting transaction is outstanding. A read may instead merge onto an outstanding read of the same line, in which case the controller sends nothing on the bus. If the controller accepts a merge with `lk_commit`, the entry is marked so that its response is captured locally. `rsp_capture` also flags responses to the client's own reads. When every entry is busy, the table reports full and refuses grants that need an entry, so that the client answers them with a NACK.

Top module: `txn_table`

## Requirements
- R1: After a synchronous active-low reset every entry is free: `tbl_full` is 0, `gnt_tag` is 0, `lk_hold` and `lk_merge` are 0, and `rsp_capture` is 0.
- R2: The tag given to a grant is the lowest-numbered free entry, and it appears on `gnt_tag` in the grant cycle.
- R3: Operation codes are 0 read, 1 read-for-ownership, 2 upgrade and 3 write-back. Only codes 0 and 1 take an entry. Grants with code 2 or 3 leave the table unchanged.
- R4: `tbl_full` is 1 exactly when all eight entries are busy. A grant with code 0 or 1 made while the table is full raises `gnt_nack` in that cycle and takes no entry.
- R5: A response with tag T frees entry T from the next cycle, whatever order responses arrive in. A response whose tag names a free entry changes nothing.
- R6: A response and a grant in the same cycle both take effect. The entry being freed is not offered to the grant in that cycle.
- R7: `lk_hold` is 1 in either of two cases: a lookup of any operation matches an outstanding read-for-ownership entry, or a lookup with code 1, 2 or 3 matches any outstanding entry.
- R8: A read lookup that matches an outstanding read entry and no read-for-ownership entry gives `lk_merge`=1, `lk_hold`=0, and that entry's tag on `lk_merge_tag`.
- R9: Addresses are compared by 128-byte line, so address bits 6..0 are ignored.
- R10: `rsp_capture` is 1 for a response to an entry in either of two cases: it was granted with source ID equal to `LOCAL_ID` (default 1), or a merge onto it was committed with `lk_commit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gnt_valid | input | 1 | A request is granted on the request bus this cycle |
| gnt_src | input | 3 | Source client ID of the granted request |
| gnt_addr | input | 32 | Byte address of the granted request |
| gnt_op | input | 2 | Operation code of the granted request |
| gnt_tag | output | 3 | Tag assigned to a grant this cycle (lowest free entry) |
| gnt_nack | output | 1 | Grant needs an entry but the table is full |
| tbl_full | output | 1 | All entries are busy |
| rsp_valid | input | 1 | A response completes on the response bus this cycle |
| rsp_tag | input | 3 | Tag of the completing response |
| rsp_capture | output | 1 | This response must be taken by the local client |
| lk_addr | input | 32 | Address of the local request under consideration |
| lk_op | input | 2 | Operation code of the local request |
| lk_commit | input | 1 | Local client accepts the offered merge |
| lk_hold | output | 1 | Local request conflicts and must wait |
| lk_merge | output | 1 | Local read may merge onto an outstanding read |
| lk_merge_tag | output | 3 | Tag of the read to merge onto |

## Verification
The bench builds the table with its default values: eight entries, 128-byte lines, 32-bit addresses and local ID 1. With eight entries the table can be filled completely in a few cycles, so NACK on full, refilling after out-of-order frees, and a grant meeting a free in the same cycle are all reached. Addresses that differ only in bits 6..0, and addresses that fall just past a line boundary, exercise the line compare from both sides.

// File: rtl/txn_table_pkg.sv
// Shared types for the outstanding request table.
// Assumes a 2-bit operation code on the request bus.
package txn_table_pkg;
    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_RDX = 2'd1,
        OP_UPG = 2'd2,
        OP_WB  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_OPEN = 2'd1,   // outstanding, response belongs elsewhere
        ST_MINE = 2'd2    // outstanding, response captured locally
    } ent_state_e;
endpackage

// File: rtl/tt_pick.sv
// Lowest-index free slot finder.
// Returns the lowest index whose busy bit is 0; none=1 when all are busy (idx=0 then).
module tt_pick #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] busy,
    output logic [TAG_W-1:0] idx,
    output logic             none
);
    // scan from the top so the lowest free index wins last
    always_comb begin
        idx  = '0;
        none = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                idx  = TAG_W'(i);
                none = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tt_match.sv
// Line-address comparator bank for local lookups.
// Assumes only read and read-for-ownership entries are ever stored.
module tt_match
    import txn_table_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int LINE_W = 25,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             valid,
    input  logic [DEPTH-1:0][LINE_W-1:0] line,
    input  bus_op_e [DEPTH-1:0]          op,
    input  logic [LINE_W-1:0]            lk_line,
    input  bus_op_e                      lk_op,
    output logic                         hold,
    output logic                         merge,
    output logic [TAG_W-1:0]             merge_tag
);
    logic [DEPTH-1:0] hold_vec;
    logic [DEPTH-1:0] merge_vec;
    logic             merge_none;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic hit;
        // per-entry line compare and hazard classification
        always_comb begin
            hit          = valid[g] && (line[g] == lk_line);
            hold_vec[g]  = hit && ((op[g] == OP_RDX) || (lk_op != OP_RD));
            merge_vec[g] = hit && (op[g] == OP_RD) && (lk_op == OP_RD);
        end
    end

    // lowest matching read is chosen as the merge target
    tt_pick #(.DEPTH(DEPTH)) u_merge_pick (
        .busy (~merge_vec),
        .idx  (merge_tag),
        .none (merge_none)
    );

    // a hold always outranks a merge
    always_comb begin
        hold  = |hold_vec;
        merge = !merge_none && !hold;
    end
endmodule

// File: rtl/txn_table.sv
// Outstanding split-transaction request table (one copy per bus client).
// Allocates a tag on each read / read-for-ownership grant, frees it on the
// matching response, and answers hold / merge questions for the local client.
// Assumes at most one grant and one response per cycle; lookups see the
// registered table, not a grant in the same cycle.
module txn_table
    import txn_table_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 32,
    parameter int SRC_W      = 3,
    parameter int LINE_BYTES = 128,
    parameter int LOCAL_ID   = 1,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_valid,
    input  logic [SRC_W-1:0]  gnt_src,
    input  logic [ADDR_W-1:0] gnt_addr,
    input  logic [1:0]        gnt_op,
    output logic [TAG_W-1:0]  gnt_tag,
    output logic              gnt_nack,
    output logic              tbl_full,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_capture,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [1:0]        lk_op,
    input  logic              lk_commit,
    output logic              lk_hold,
    output logic              lk_merge,
    output logic [TAG_W-1:0]  lk_merge_tag
);
    ent_state_e [DEPTH-1:0]        state_q;
    logic [DEPTH-1:0][LINE_W-1:0]  line_q;
    bus_op_e [DEPTH-1:0]           op_q;
    logic [DEPTH-1:0][SRC_W-1:0]   src_q;
    logic [DEPTH-1:0]              valid_q;

    logic    needs_entry;
    logic    alloc;
    logic    do_free;
    logic    do_mark;
    bus_op_e gnt_op_e;

    // busy vector seen by the picker, comparators and checker
    always_comb begin
        for (int i = 0; i < DEPTH; i++) valid_q[i] = (state_q[i] != ST_FREE);
    end

    tt_pick #(.DEPTH(DEPTH)) u_free_pick (
        .busy (valid_q),
        .idx  (gnt_tag),
        .none (tbl_full)
    );

    tt_match #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_match (
        .valid     (valid_q),
        .line      (line_q),
        .op        (op_q),
        .lk_line   (lk_addr[ADDR_W-1:OFF_W]),
        .lk_op     (bus_op_e'(lk_op)),
        .hold      (lk_hold),
        .merge     (lk_merge),
        .merge_tag (lk_merge_tag)
    );

    // grant decode: only ops with a response phase take an entry
    always_comb begin
        gnt_op_e    = bus_op_e'(gnt_op);
        needs_entry = gnt_valid && ((gnt_op_e == OP_RD) || (gnt_op_e == OP_RDX));
        alloc       = needs_entry && !tbl_full;
        gnt_nack    = needs_entry && tbl_full;
        do_free     = rsp_valid && valid_q[rsp_tag];
        do_mark     = lk_merge && lk_commit;
        rsp_capture = rsp_valid && (state_q[rsp_tag] == ST_MINE);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // entry state: free wins, then allocate, then merge marking
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[g] <= ST_FREE;
            end else if (do_free && (rsp_tag == TAG_W'(g))) begin
                state_q[g] <= ST_FREE;
            end else if (alloc && (gnt_tag == TAG_W'(g))) begin
                state_q[g] <= (gnt_src == SRC_W'(LOCAL_ID)) ? ST_MINE : ST_OPEN;
            end else if (do_mark && (lk_merge_tag == TAG_W'(g))) begin
                state_q[g] <= ST_MINE;
            end
        end

        // entry payload captured at allocation, no reset needed
        always_ff @(posedge clk) begin
            if (alloc && (gnt_tag == TAG_W'(g))) begin
                line_q[g] <= gnt_addr[ADDR_W-1:OFF_W];
                op_q[g]   <= gnt_op_e;
                src_q[g]  <= gnt_src;
            end
        end
    end
endmodule

// File: rtl/txn_table_chk.sv
// Assertion checker for txn_table, attached by bind below.
module txn_table_chk #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gnt_valid,
    input logic [1:0]       gnt_op,
    input logic [TAG_W-1:0] gnt_tag,
    input logic             gnt_nack,
    input logic             tbl_full,
    input logic             rsp_valid,
    input logic [TAG_W-1:0] rsp_tag,
    input logic             lk_hold,
    input logic             lk_merge,
    input logic [DEPTH-1:0] valid_q
);
    a_r2_tag_is_free: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_full |-> !valid_q[gnt_tag]);

    a_r3_no_entry_op: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && gnt_op[1] && !rsp_valid) |=> (valid_q == $past(valid_q)));

    a_r4_nack_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_nack |-> tbl_full);

    a_r4_nack_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_nack && !rsp_valid) |=> (valid_q == $past(valid_q)));

    a_r5_resp_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && valid_q[rsp_tag]) |=> !valid_q[$past(rsp_tag)]);

    a_r6_both_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_op[1] && !tbl_full && rsp_valid && valid_q[rsp_tag])
        |=> (valid_q[$past(gnt_tag)] && !valid_q[$past(rsp_tag)]));

    a_r8_merge_not_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hold && lk_merge));
endmodule

bind txn_table txn_table_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_valid (gnt_valid),
    .gnt_op    (gnt_op),
    .gnt_tag   (gnt_tag),
    .gnt_nack  (gnt_nack),
    .tbl_full  (tbl_full),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .lk_hold   (lk_hold),
    .lk_merge  (lk_merge),
    .valid_q   (valid_q)
);

// File: tb/txn_table_test.sv
// Scoreboard bench: the driver predicts the tag (or NACK) of each
// entry-taking grant into a queue; a monitor pops and compares.
module txn_table_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gnt_valid = 1'b0;
    logic [2:0]  gnt_src = '0;
    logic [31:0] gnt_addr = '0;
    logic [1:0]  gnt_op = '0;
    logic [2:0]  gnt_tag;
    logic        gnt_nack;
    logic        tbl_full;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_tag = '0;
    logic        rsp_capture;
    logic [31:0] lk_addr = '0;
    logic [1:0]  lk_op = '0;
    logic        lk_commit = 1'b0;
    logic        lk_hold;
    logic        lk_merge;
    logic [2:0]  lk_merge_tag;

    int n_checks = 0;
    int n_errors = 0;
    int exp_q[$];
    logic [7:0] mv = '0;   // bench's own busy map

    txn_table uut (.*);

    always #5 clk = ~clk;

    task automatic chk(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // monitor: compares each entry-taking grant against the prediction
    always @(negedge clk) begin
        #2;
        if (rst_n && gnt_valid && !gnt_op[1]) begin
            if (exp_q.size() == 0) chk("R2 scoreboard underflow", 1, 0);
            else chk("R2/R4 grant tag or nack", gnt_nack ? -1 : int'(gnt_tag), exp_q.pop_front());
        end
    end

    // one bus cycle: optional grant and optional response
    task automatic cyc(bit gv, logic [1:0] op, logic [31:0] a, logic [2:0] src, bit rv, logic [2:0] rt);
        int e;
        @(negedge clk);
        gnt_valid = gv; gnt_op = op; gnt_addr = a; gnt_src = src;
        rsp_valid = rv; rsp_tag = rt; lk_commit = 1'b0;
        e = -1;
        for (int i = 7; i >= 0; i--) if (!mv[i]) e = i;
        if (gv && !op[1]) begin
            exp_q.push_back(e);
            if (e >= 0) mv[e] = 1'b1;
        end
        if (rv) mv[rt] = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        gnt_valid = 0; rsp_valid = 0; lk_commit = 0;
    endtask

    task automatic look(logic [31:0] a, logic [1:0] op, bit commit, int eh, int em, int et, string req);
        @(negedge clk);
        gnt_valid = 0; rsp_valid = 0;
        lk_addr = a; lk_op = op; lk_commit = commit;
        #2;
        chk({req, " hold"}, int'(lk_hold), eh);
        chk({req, " merge"}, int'(lk_merge), em);
        if (em == 1) chk({req, " merge tag"}, int'(lk_merge_tag), et);
    endtask

    task automatic resp(logic [2:0] t, int ecap, string req);
        cyc(0, 2'd0, '0, '0, 1, t);
        #2;
        chk(req, int'(rsp_capture), ecap);
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1 full", int'(tbl_full), 0);
        chk("R1 tag", int'(gnt_tag), 0);
        chk("R1 hold", int'(lk_hold), 0);
        chk("R1 merge", int'(lk_merge), 0);
        chk("R1 capture", int'(rsp_capture), 0);

        // R2/R3 allocation; upgrade and write-back take nothing
        cyc(1, 2'd1, 32'h1000, 3'd2, 0, 0);   // tag0 RDX
        cyc(1, 2'd0, 32'h2000, 3'd5, 0, 0);   // tag1 RD
        cyc(1, 2'd0, 32'h3000, 3'd1, 0, 0);   // tag2 RD local
        cyc(1, 2'd2, 32'h4000, 3'd4, 0, 0);   // R3 upgrade
        cyc(1, 2'd3, 32'h4100, 3'd4, 0, 0);   // R3 write-back
        cyc(1, 2'd0, 32'h5000, 3'd3, 0, 0);   // R3 expects tag3

        // R7/R8/R9 lookups
        look(32'h1040, 2'd0, 0, 1, 0, 0, "R7 R9 read vs RDX same line");
        look(32'h207F, 2'd0, 0, 0, 1, 1, "R8 R9 read merges");
        look(32'h2000, 2'd1, 0, 1, 0, 0, "R7 RDX vs read");
        look(32'h2080, 2'd0, 0, 0, 0, 0, "R9 next line");
        look(32'h5000, 2'd2, 0, 1, 0, 0, "R7 upgrade vs read");
        look(32'h6000, 2'd3, 0, 0, 0, 0, "R7 no match");
        look(32'h2000, 2'd0, 1, 0, 1, 1, "R10 commit merge");

        // R5/R10 out-of-order responses
        resp(3'd1, 1, "R10 merged capture");
        resp(3'd0, 0, "R10 foreign no capture");
        cyc(1, 2'd0, 32'h7000, 3'd4, 0, 0);   // R2 reuses tag0
        resp(3'd5, 0, "R5 free tag response");
        cyc(1, 2'd0, 32'h8000, 3'd4, 0, 0);   // R5 expects tag1
        resp(3'd2, 1, "R10 local capture");
        look(32'h3000, 2'd1, 0, 0, 0, 0, "R5 freed line no hold");

        // R4 fill and NACK
        for (int k = 0; k < 5; k++) cyc(1, 2'd0, 32'h9000 + 32'(k) * 32'h80, 3'd6, 0, 0);
        idle(); #2;
        chk("R4 full", int'(tbl_full), 1);
        cyc(1, 2'd0, 32'hA000, 3'd6, 0, 0);   // R4 nack
        cyc(1, 2'd1, 32'hA080, 3'd6, 0, 0);   // R4 nack
        idle(); #2;
        chk("R4 still full", int'(tbl_full), 1);

        // R6 grant and free in one cycle
        resp(3'd4, 0, "R6 setup free");
        cyc(1, 2'd0, 32'hB000, 3'd6, 1, 3'd6); // expects tag4, frees 6
        cyc(1, 2'd0, 32'hB080, 3'd6, 0, 0);    // expects tag6
        idle(); #2;
        chk("R6 full again", int'(tbl_full), 1);
        chk("R2 scoreboard drained", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule